// File: doc/BRIEF.md
# Unlock-Sequence Command Decoder

This block sits behind the write port of a word-wide non-volatile memory and turns a stream of bus write cycles into memory instructions. Each write cycle is presented as a single-cycle strobe with a 16-bit address and a 16-bit data word. The decoder knows four instructions: return to array reads, signature read, single-word program and whole-chip erase. Program and erase run only after fixed address/data unlock pairs have been written. A cycle that does not match what the sequence expects drops the decoder back to array reads with no further effect.

The decoder drives a read-mode selector for the read path: array data, fixed signature words or engine status. It also drives one-cycle start pulses to the program/erase engine, with the target address and data of a program held on dedicated outputs. The engine reports busy and fail flags. While the engine is busy, writes are ignored. The one exception is a reset command while a failure is flagged. A small lookup returns the two signature words from the low address bits.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Reset puts the decoder in array-read mode (rd_mode = 2'b00), with no start pulse and an idle sequence.
- R2: An unlock pair is data AAh at address 555h, then data 55h at address 2AAh. Only address bits 10:0 and data bits 7:0 are compared. Higher address bits have no effect.
- R3: The program sequence is unlock pair, then A0h to address 555h, then the target write. prog_start is high for the cycle after the target write. tgt_addr and tgt_data then hold that write's address and data.
- R4: The erase sequence is unlock pair, 80h to 555h, a second unlock pair, then a write whose data bits 7:0 are 10h. erase_start is high for the cycle after that sixth write, and not before.
- R5: A wrong address or data in any cycle, including a wrong confirm code or a command written to an address other than 555h, returns the decoder to array mode and to the start of the sequence. No start pulse is issued.
- R6: A reset command F0h, written either alone or after the unlock pair, leaves the decoder in array mode with the sequence idle.
- R7: Unlock pair followed by 90h at 555h selects signature mode (rd_mode = 2'b01). The next accepted write returns the decoder to array mode.
- R8: sig_word is 0020h for sig_sel = 2'b00, 00C1h for 2'b01, and 0000h otherwise. The upper byte is always zero.
- R9: rd_mode is 2'b10 (status) whenever eng_busy or eng_fail is high.
- R10: While eng_busy is high and eng_fail is low, writes are ignored. They neither advance nor abort the sequence.
- R11: While eng_busy and eng_fail are both high, a write with data F0h returns the sequence to idle and the stored mode to array. Other writes are ignored.
- R12: prog_start and erase_start are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle strobe per bus write |
| wr_addr | input | 16 | Write address |
| wr_data | input | 16 | Write data |
| eng_busy | input | 1 | Program/erase engine running |
| eng_fail | input | 1 | Program/erase engine reports failure |
| sig_sel | input | 2 | Low address bits for a signature read |
| rd_mode | output | 2 | Read-path mode: 00 array, 01 signature, 10 status |
| sig_word | output | 16 | Signature word for sig_sel |
| prog_start | output | 1 | Start pulse for a word program |
| erase_start | output | 1 | Start pulse for a chip erase |
| tgt_addr | output | 16 | Latched program address |
| tgt_data | output | 16 | Latched program data |

## Verification
A write sampled at a rising edge changes the stored mode and the start pulses on that same edge. The result is therefore visible for the whole following cycle and is gone after one more edge. The bench drives each write on a falling edge and removes the strobe on the next falling edge. It checks rd_mode, prog_start, erase_start and the target outputs at that point, and checks one cycle later that the pulses have dropped. sig_word and the status override of rd_mode are combinational, so the bench samples them on the falling edge where the inputs change. The ignore and reset-under-failure cases are judged by whether a follow-on command produces a start pulse.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PGM, SQ_ERA1, SQ_ERA2, SQ_ERA3
  } seq_t;

  localparam logic [1:0] RM_ARRAY  = 2'b00;
  localparam logic [1:0] RM_SIG    = 2'b01;
  localparam logic [1:0] RM_STATUS = 2'b10;

  localparam logic [7:0] CODE_UNL1    = 8'hAA;
  localparam logic [7:0] CODE_UNL2    = 8'h55;
  localparam logic [7:0] CODE_RESET   = 8'hF0;
  localparam logic [7:0] CODE_AUTOSEL = 8'h90;
  localparam logic [7:0] CODE_PROG    = 8'hA0;
  localparam logic [7:0] CODE_ERSET   = 8'h80;
  localparam logic [7:0] CODE_ERCONF  = 8'h10;

  localparam logic [10:0] ADR_UNL1 = 11'h555;
  localparam logic [10:0] ADR_UNL2 = 11'h2AA;

  localparam logic [7:0] SIG_MFR = 8'h20;
  localparam logic [7:0] SIG_DEV = 8'hC1;
endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
  import flash_cmd_pkg::*;
#(
  parameter int CMP_W  = 11,
  parameter int CODE_W = 8
) (
  input  logic [CMP_W-1:0]  cmp_addr,
  input  logic [CODE_W-1:0] code,
  output logic              hit_unl1,
  output logic              hit_unl2,
  output logic              on_cmd_addr
);
  localparam logic [CMP_W-1:0]  A_UNL1 = CMP_W'(ADR_UNL1);
  localparam logic [CMP_W-1:0]  A_UNL2 = CMP_W'(ADR_UNL2);
  localparam logic [CODE_W-1:0] D_UNL1 = CODE_W'(CODE_UNL1);
  localparam logic [CODE_W-1:0] D_UNL2 = CODE_W'(CODE_UNL2);

  always_comb begin
    on_cmd_addr = (cmp_addr == A_UNL1);
    hit_unl1    = on_cmd_addr && (code == D_UNL1);
    hit_unl2    = (cmp_addr == A_UNL2) && (code == D_UNL2);
  end
endmodule

// File: rtl/flash_cmd_sig.sv
module flash_cmd_sig
  import flash_cmd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [1:0]        sel,
  output logic [DATA_W-1:0] word
);
  always_comb begin
    case (sel)
      2'b00:   word = DATA_W'(SIG_MFR);
      2'b01:   word = DATA_W'(SIG_DEV);
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CMP_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              eng_busy,
  input  logic              eng_fail,
  input  logic [1:0]        sig_sel,
  output logic [1:0]        rd_mode,
  output logic [DATA_W-1:0] sig_word,
  output logic              prog_start,
  output logic              erase_start,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_data
);
  localparam int CODE_W = 8;

  logic [CODE_W-1:0] code;
  logic hit_unl1, hit_unl2, on_cmd_addr;
  seq_t seq_q, seq_d;
  logic sig_q, sig_d;
  logic pstart_d, estart_d;
  logic [ADDR_W-1:0] tadr_d;
  logic [DATA_W-1:0] tdat_d;

  assign code = wr_data[CODE_W-1:0];

  flash_cmd_match #(.CMP_W(CMP_W), .CODE_W(CODE_W)) u_match (
    .cmp_addr   (wr_addr[CMP_W-1:0]),
    .code       (code),
    .hit_unl1   (hit_unl1),
    .hit_unl2   (hit_unl2),
    .on_cmd_addr(on_cmd_addr)
  );

  flash_cmd_sig #(.DATA_W(DATA_W)) u_sig (
    .sel (sig_sel),
    .word(sig_word)
  );

  // Next-state decode
  always_comb begin
    seq_d    = seq_q;
    sig_d    = sig_q;
    pstart_d = 1'b0;
    estart_d = 1'b0;
    tadr_d   = tgt_addr;
    tdat_d   = tgt_data;
    if (wr_stb) begin
      if (eng_busy) begin
        if (eng_fail && code == CODE_RESET) begin
          seq_d = SQ_IDLE;
          sig_d = 1'b0;
        end
      end else begin
        seq_d = SQ_IDLE;
        sig_d = 1'b0;
        case (seq_q)
          SQ_IDLE: if (hit_unl1) seq_d = SQ_UNL1;
          SQ_UNL1: if (hit_unl2) seq_d = SQ_UNL2;
          SQ_UNL2: begin
            if (on_cmd_addr) begin
              case (code)
                CODE_AUTOSEL: sig_d = 1'b1;
                CODE_PROG:    seq_d = SQ_PGM;
                CODE_ERSET:   seq_d = SQ_ERA1;
                default:      seq_d = SQ_IDLE;
              endcase
            end
          end
          SQ_PGM: begin
            pstart_d = 1'b1;
            tadr_d   = wr_addr;
            tdat_d   = wr_data;
          end
          SQ_ERA1: if (hit_unl1) seq_d = SQ_ERA2;
          SQ_ERA2: if (hit_unl2) seq_d = SQ_ERA3;
          SQ_ERA3: if (code == CODE_ERCONF) estart_d = 1'b1;
          default: seq_d = SQ_IDLE;
        endcase
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q       <= SQ_IDLE;
      sig_q       <= 1'b0;
      prog_start  <= 1'b0;
      erase_start <= 1'b0;
    end else begin
      prog_start  <= pstart_d;
      erase_start <= estart_d;
      if (wr_stb) begin
        seq_q <= seq_d;
        sig_q <= sig_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_addr <= '0;
      tgt_data <= '0;
    end else if (pstart_d) begin
      tgt_addr <= tadr_d;
      tgt_data <= tdat_d;
    end
  end

  always_comb begin
    if (eng_busy || eng_fail) rd_mode = RM_STATUS;
    else if (sig_q)           rd_mode = RM_SIG;
    else                      rd_mode = RM_ARRAY;
  end
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              eng_busy,
  input logic              eng_fail,
  input logic [1:0]        rd_mode,
  input logic              prog_start,
  input logic              erase_start,
  input logic [ADDR_W-1:0] tgt_addr,
  input logic [DATA_W-1:0] tgt_data
);
  // R12
  start_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_start && erase_start));

  // R12
  prog_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);

  // R12
  erase_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  // R10
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && eng_busy && !eng_fail) |=> (!prog_start && !erase_start));

  // R9
  status_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy || eng_fail) |-> (rd_mode == 2'b10));

  // R4
  erase_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> ($past(wr_stb) && $past(wr_data[7:0]) == 8'h10));

  // R3
  prog_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> ($past(wr_stb) && tgt_addr == $past(wr_addr)
                    && tgt_data == $past(wr_data)));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
  .eng_busy(eng_busy), .eng_fail(eng_fail), .rd_mode(rd_mode),
  .prog_start(prog_start), .erase_start(erase_start),
  .tgt_addr(tgt_addr), .tgt_data(tgt_data)
);

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_stb;
  logic [15:0] wr_addr, wr_data;
  logic        eng_busy, eng_fail;
  logic [1:0]  sig_sel;
  logic [1:0]  rd_mode;
  logic [15:0] sig_word;
  logic        prog_start, erase_start;
  logic [15:0] tgt_addr, tgt_data;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .eng_busy(eng_busy), .eng_fail(eng_fail), .sig_sel(sig_sel), .rd_mode(rd_mode),
    .sig_word(sig_word), .prog_start(prog_start), .erase_start(erase_start),
    .tgt_addr(tgt_addr), .tgt_data(tgt_data)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one write; returns on the falling edge after the capturing rising edge
  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic unlock();
    wr(16'h0555, 16'h00AA);
    wr(16'h02AA, 16'h0055);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wr_stb = 1'b0; wr_addr = '0; wr_data = '0;
    eng_busy = 1'b0; eng_fail = 1'b0; sig_sel = 2'b00;
    repeat (3) @(negedge clk);
    chk("R1 rd_mode", {14'd0, rd_mode}, 16'h0000);
    chk("R1 starts", {14'd0, prog_start, erase_start}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {14'd0, rd_mode}, 16'h0000);
  endtask

  task automatic t_program();
    unlock();
    wr(16'h0555, 16'h00A0);
    chk("R3 no early start", {15'd0, prog_start}, 16'h0000);
    wr(16'h1234, 16'hBEEF);
    chk("R3 prog_start", {15'd0, prog_start}, 16'h0001);
    chk("R3 tgt_addr", tgt_addr, 16'h1234);
    chk("R3 tgt_data", tgt_data, 16'hBEEF);
    chk("R12 no erase with prog", {15'd0, erase_start}, 16'h0000);
    @(negedge clk);
    chk("R12 prog pulse width", {15'd0, prog_start}, 16'h0000);
  endtask

  task automatic t_erase();
    unlock();
    wr(16'h0555, 16'h0080);
    unlock();
    chk("R4 no early erase", {15'd0, erase_start}, 16'h0000);
    wr(16'h0555, 16'h0010);
    chk("R4 erase_start", {15'd0, erase_start}, 16'h0001);
    @(negedge clk);
    chk("R12 erase pulse width", {15'd0, erase_start}, 16'h0000);
  endtask

  task automatic t_masking();
    wr(16'hF555, 16'hFFAA);
    wr(16'h7AAA, 16'h1255);
    wr(16'h0D55, 16'h00A0);
    wr(16'h4321, 16'h5A5A);
    chk("R2 high address bits ignored", {15'd0, prog_start}, 16'h0001);
    chk("R2 tgt_addr", tgt_addr, 16'h4321);
    wr(16'h0155, 16'h00AA);
    wr(16'h02AA, 16'h0055);
    wr(16'h0555, 16'h00A0);
    wr(16'h0100, 16'h0001);
    chk("R2 bit 10 compared", {15'd0, prog_start}, 16'h0000);
  endtask

  task automatic t_abort();
    wr(16'h0555, 16'h00AA);
    wr(16'h02AA, 16'h0056);
    wr(16'h0555, 16'h00A0);
    wr(16'h0010, 16'h0011);
    chk("R5 bad second unlock", {15'd0, prog_start}, 16'h0000);
    unlock();
    wr(16'h0554, 16'h00A0);
    wr(16'h0010, 16'h0011);
    chk("R5 command at wrong address", {15'd0, prog_start}, 16'h0000);
    unlock();
    wr(16'h0555, 16'h0080);
    unlock();
    wr(16'h0555, 16'h0030);
    chk("R5 wrong confirm", {15'd0, erase_start}, 16'h0000);
    chk("R5 mode after abort", {14'd0, rd_mode}, 16'h0000);
  endtask

  task automatic t_autoselect();
    unlock();
    wr(16'h0555, 16'h0090);
    chk("R7 signature mode", {14'd0, rd_mode}, 16'h0001);
    sig_sel = 2'b00; #1;
    chk("R8 manufacturer code", sig_word, 16'h0020);
    sig_sel = 2'b01; #1;
    chk("R8 device code", sig_word, 16'h00C1);
    sig_sel = 2'b10; #1;
    chk("R8 other select", sig_word, 16'h0000);
    wr(16'h0000, 16'h0000);
    chk("R7 next write leaves signature", {14'd0, rd_mode}, 16'h0000);
    unlock();
    wr(16'h0555, 16'h0090);
    wr(16'h0000, 16'h00F0);
    chk("R6 single reset", {14'd0, rd_mode}, 16'h0000);
  endtask

  task automatic t_reset_cmd();
    unlock();
    wr(16'h0555, 16'h00F0);
    chk("R6 reset after unlock mode", {14'd0, rd_mode}, 16'h0000);
    wr(16'h0555, 16'h00A0);
    wr(16'h0020, 16'h0022);
    chk("R6 sequence idle after reset", {15'd0, prog_start}, 16'h0000);
  endtask

  task automatic t_busy();
    @(negedge clk);
    eng_busy = 1'b1; #1;
    chk("R9 status while busy", {14'd0, rd_mode}, 16'h0002);
    eng_busy = 1'b0; eng_fail = 1'b1; #1;
    chk("R9 status while failed", {14'd0, rd_mode}, 16'h0002);
    eng_fail = 1'b0;
    unlock();
    @(negedge clk); eng_busy = 1'b1;
    wr(16'h0555, 16'h00A0);
    wr(16'h0123, 16'h0000);
    @(negedge clk); eng_busy = 1'b0;
    wr(16'h0555, 16'h00A0);
    wr(16'h0777, 16'h1111);
    chk("R10 busy writes ignored", {15'd0, prog_start}, 16'h0001);
    chk("R10 target from later write", tgt_addr, 16'h0777);
  endtask

  task automatic t_fail_reset();
    unlock();
    @(negedge clk); eng_busy = 1'b1; eng_fail = 1'b1;
    wr(16'h0000, 16'h00F0);
    @(negedge clk); eng_busy = 1'b0; eng_fail = 1'b0;
    wr(16'h0555, 16'h00A0);
    wr(16'h0400, 16'h0044);
    chk("R11 reset accepted on failure", {15'd0, prog_start}, 16'h0000);
    chk("R11 mode array", {14'd0, rd_mode}, 16'h0000);
  endtask

  initial begin
    t_reset();
    t_program();
    t_erase();
    t_masking();
    t_abort();
    t_autoselect();
    t_reset_cmd();
    t_busy();
    t_fail_reset();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule